// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This block holds a small bank of hardware semaphore flags that two independent agents, a left port and a right port, use to agree on who owns a shared resource. Each port has its own strobe, chip-enable, write enable, flag address and data bus. A port asks for a flag by writing to it. It then reads the flag back in a later, separate cycle to learn whether it was granted. A port gives the flag up by writing to it again.

Ownership, queued requests and same-cycle contention are resolved inside the block, one clock edge at a time. A request that arrives while the other port holds a flag is remembered. When the owner lets go, the flag passes straight to the waiting port. When both ports ask for a free flag on the same edge, the left port always wins. Each port sees every flag from its own point of view, so a port reads 0 only for flags it holds.

All pins are plain control and status signals. A semaphore cycle is a single-cycle strobe with no handshake, so the block applies no back-pressure and needs no valid/ready pairing. The read byte is registered and appears in the cycle after the read strobe.

Top module: `sem_flag_unit`

## Requirements
- R1: After a synchronous reset every flag is free and no request is pending, and both read data buses hold 8'hFF.
- R2: A port takes part in a semaphore access only in a cycle where its strobe is 1 and its chip-enable is 0. In any other cycle, flag state and that port's read data are unchanged.
- R3: Only bit 0 of the write data counts: 0 requests the addressed flag and 1 releases it. All other data bits are ignored.
- R4: A read access loads all eight bits of that port's read data with the same value on the next clock edge. The value is 0 if that port owns the addressed flag and 1 otherwise, so a free flag reads 8'hFF from both ports.
- R5: A request to a free flag grants it to the requesting port on that clock edge.
- R6: A request from the non-owner of a held flag is kept pending. On the edge where the owner releases the flag, ownership passes to the pending port.
- R7: If both ports request the same free flag on one edge, the left port becomes owner and the right port's request becomes pending.
- R8: A release written by a port that does not own the flag cancels only that port's own pending request and changes nothing else.
- R9: The eight flags, selected by the 3-bit address, act independently of one another.
- R10: A flag never has more than one owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem | input | 1 | Left semaphore strobe |
| l_ce | input | 1 | Left memory chip-enable; must be 0 for a semaphore access |
| l_we | input | 1 | Left write (1) or read (0) |
| l_addr | input | 3 | Left flag select |
| l_wdata | input | 8 | Left write data; bit 0 used |
| l_rdata | output | 8 | Left registered read data |
| r_sem | input | 1 | Right semaphore strobe |
| r_ce | input | 1 | Right memory chip-enable; must be 0 for a semaphore access |
| r_we | input | 1 | Right write (1) or read (0) |
| r_addr | input | 3 | Right flag select |
| r_wdata | input | 8 | Right write data; bit 0 used |
| r_rdata | output | 8 | Right registered read data |

## Verification
The bench builds the block with its default parameters: eight flags and an eight-bit data bus. With these values both end addresses, 0 and 7, can be reached, and every read byte can be compared against 8'h00 or 8'hFF. Directed scenarios cover grant, hand-off to a waiting port, same-edge contention, release by a non-owner, the masking of data bits above bit 0, and accesses gated off by the strobe or the chip-enable. The bound checker watches the per-flag owner and pending state on every edge.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;
endpackage

// File: rtl/sem_access_decode.sv
module sem_access_decode #(
  parameter int NF = 8,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          sem,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [NF-1:0] req,
  output logic [NF-1:0] rel,
  output logic          rd_en
);
  logic active;
  logic wr_en;

  assign active = sem & ~ce;
  assign wr_en  = active & we;
  assign rd_en  = active & ~we;

  always_comb begin
    req = '0;
    rel = '0;
    for (int i = 0; i < NF; i++) begin
      if (wr_en && (addr == AW'(i))) begin
        req[i] = ~wdata[0];
        rel[i] = wdata[0];
      end
    end
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lreq,
  input  logic lrel,
  input  logic rreq,
  input  logic rrel,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);
  holder_e holder_q, holder_d;
  logic    pl_q, pr_q, pl_d, pr_d;
  logic    pl_nx, pr_nx, freed;

  always_comb begin
    pl_nx = pl_q;
    pr_nx = pr_q;
    if (holder_q != HOLD_LEFT) begin
      if (lreq) pl_nx = 1'b1;
      if (lrel) pl_nx = 1'b0;
    end
    if (holder_q != HOLD_RIGHT) begin
      if (rreq) pr_nx = 1'b1;
      if (rrel) pr_nx = 1'b0;
    end
    freed = (holder_q == HOLD_NONE) ||
            (holder_q == HOLD_LEFT  && lrel) ||
            (holder_q == HOLD_RIGHT && rrel);
    holder_d = holder_q;
    pl_d     = pl_nx;
    pr_d     = pr_nx;
    if (freed) begin
      if (pl_nx) begin
        holder_d = HOLD_LEFT;
        pl_d     = 1'b0;
      end else if (pr_nx) begin
        holder_d = HOLD_RIGHT;
        pr_d     = 1'b0;
      end else begin
        holder_d = HOLD_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holder_q <= HOLD_NONE;
      pl_q     <= 1'b0;
      pr_q     <= 1'b0;
    end else begin
      holder_q <= holder_d;
      pl_q     <= pl_d;
      pr_q     <= pr_d;
    end
  end

  assign own_l  = (holder_q == HOLD_LEFT);
  assign own_r  = (holder_q == HOLD_RIGHT);
  assign pend_l = pl_q;
  assign pend_r = pr_q;
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NF = 8,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [NF-1:0] mine,
  output logic [DW-1:0] rdata
);
  logic view;

  assign view = ~mine[addr];

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_en) rdata <= {DW{view}};
  end
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sem,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] lreq, lrel, rreq, rrel;
  logic [NUM_FLAGS-1:0] own_l, own_r, pend_l, pend_r;
  logic                 l_rd, r_rd;

  sem_access_decode #(.NF(NUM_FLAGS), .AW(ADDR_W), .DW(DATA_W)) u_dec_l (
    .sem(l_sem), .ce(l_ce), .we(l_we), .addr(l_addr), .wdata(l_wdata),
    .req(lreq), .rel(lrel), .rd_en(l_rd)
  );

  sem_access_decode #(.NF(NUM_FLAGS), .AW(ADDR_W), .DW(DATA_W)) u_dec_r (
    .sem(r_sem), .ce(r_ce), .we(r_we), .addr(r_addr), .wdata(r_wdata),
    .req(rreq), .rel(rrel), .rd_en(r_rd)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .lreq(lreq[g]), .lrel(lrel[g]), .rreq(rreq[g]), .rrel(rrel[g]),
      .own_l(own_l[g]), .own_r(own_r[g]),
      .pend_l(pend_l[g]), .pend_r(pend_r[g])
    );
  end

  sem_read_port #(.NF(NUM_FLAGS), .AW(ADDR_W), .DW(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd), .addr(l_addr), .mine(own_l),
    .rdata(l_rdata)
  );

  sem_read_port #(.NF(NUM_FLAGS), .AW(ADDR_W), .DW(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd), .addr(r_addr), .mine(own_r),
    .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_flag_unit_chk.sv
module sem_flag_unit_chk #(
  parameter int NF = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          l_sem,
  input logic          l_ce,
  input logic          r_sem,
  input logic          r_ce,
  input logic [DW-1:0] l_rdata,
  input logic [DW-1:0] r_rdata,
  input logic [NF-1:0] lreq,
  input logic [NF-1:0] lrel,
  input logic [NF-1:0] rreq,
  input logic [NF-1:0] rrel,
  input logic [NF-1:0] own_l,
  input logic [NF-1:0] own_r,
  input logic [NF-1:0] pend_l,
  input logic [NF-1:0] pend_r
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (own_l == '0 && own_r == '0 && pend_l == '0 && pend_r == '0
             && l_rdata == '1 && r_rdata == '1));

  assert_gated_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ((!l_sem || l_ce) && (!r_sem || r_ce)) |=>
      ($stable(own_l) && $stable(own_r) && $stable(pend_l) && $stable(pend_r)
       && $stable(l_rdata) && $stable(r_rdata)));

  assert_uniform_byte_R4: assert property (@(posedge clk) disable iff (rst)
    ((l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1)));

  for (genvar g = 0; g < NF; g++) begin : g_chk
    assert_free_grant_R5: assert property (@(posedge clk) disable iff (rst)
      (!own_l[g] && !own_r[g] && lreq[g]) |=> own_l[g]);

    assert_handoff_R6: assert property (@(posedge clk) disable iff (rst)
      (own_l[g] && pend_r[g] && lrel[g] && !rrel[g]) |=> own_r[g]);

    assert_left_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (!own_l[g] && !own_r[g] && lreq[g] && rreq[g]) |=> (own_l[g] && pend_r[g]));

    assert_foreign_release_R8: assert property (@(posedge clk) disable iff (rst)
      (own_l[g] && rrel[g] && !lrel[g]) |=> (own_l[g] && !pend_r[g]));

    assert_one_owner_R10: assert property (@(posedge clk) disable iff (rst)
      !(own_l[g] && own_r[g]));
  end
endmodule

bind sem_flag_unit sem_flag_unit_chk #(.NF(NUM_FLAGS), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sem(l_sem), .l_ce(l_ce), .r_sem(r_sem), .r_ce(r_ce),
  .l_rdata(l_rdata), .r_rdata(r_rdata),
  .lreq(lreq), .lrel(lrel), .rreq(rreq), .rrel(rrel),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/tb_sem_flag_unit.sv
module tb_sem_flag_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       l_sem, l_ce, l_we, r_sem, r_ce, r_we;
  logic [2:0] l_addr, r_addr;
  logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;
  int         nchk = 0;
  int         nbad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  sem_flag_unit dut (
    .clk(clk), .rst(rst),
    .l_sem(l_sem), .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem(r_sem), .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sem = 0; l_ce = 1; l_we = 0; l_addr = 0; l_wdata = 8'hFF;
    r_sem = 0; r_ce = 1; r_we = 0; r_addr = 0; r_wdata = 8'hFF;
  endtask

  // One cycle with both ports driven; port is enabled when en=1.
  task automatic step(input bit len, input bit lwe, input logic [2:0] la,
                      input logic [7:0] ld, input bit ren, input bit rwe,
                      input logic [2:0] ra, input logic [7:0] rd);
    l_sem = len; l_ce = 0; l_we = lwe; l_addr = la; l_wdata = ld;
    r_sem = ren; r_ce = 0; r_we = rwe; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic lwr(input logic [2:0] a, input logic [7:0] d);
    step(1, 1, a, d, 0, 0, 0, 8'hFF);
  endtask
  task automatic rwr(input logic [2:0] a, input logic [7:0] d);
    step(0, 0, 0, 8'hFF, 1, 1, a, d);
  endtask
  task automatic both_rd(input logic [2:0] a);
    step(1, 0, a, 8'h00, 1, 0, a, 8'h00);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      both_rd(3'(i));
      chk(l_rdata, 8'hFF, "R1 left free after reset");
      chk(r_rdata, 8'hFF, "R1 right free after reset");
    end
  endtask

  task automatic t_grant();
    lwr(3, 8'h00);
    both_rd(3);
    chk(l_rdata, 8'h00, "R5 left granted, R4 owner reads 0");
    chk(r_rdata, 8'hFF, "R4 non-owner reads FF");
  endtask

  task automatic t_handoff();
    rwr(3, 8'h00);
    both_rd(3);
    chk(r_rdata, 8'hFF, "R6 right pending not owner");
    chk(l_rdata, 8'h00, "R6 left still owner");
    lwr(3, 8'h01);
    both_rd(3);
    chk(r_rdata, 8'h00, "R6 right owns after hand-off");
    chk(l_rdata, 8'hFF, "R6 left released");
    rwr(3, 8'h01);
    both_rd(3);
    chk(r_rdata, 8'hFF, "R6 flag free after right release");
  endtask

  task automatic t_foreign_release();
    lwr(5, 8'h00);
    rwr(5, 8'h00);
    rwr(5, 8'h01);
    both_rd(5);
    chk(l_rdata, 8'h00, "R8 left keeps flag after foreign release");
    lwr(5, 8'h01);
    both_rd(5);
    chk(r_rdata, 8'hFF, "R8 right pending cancelled");
    chk(l_rdata, 8'hFF, "R8 flag free");
  endtask

  task automatic t_contention();
    step(1, 1, 7, 8'h00, 1, 1, 7, 8'h00);
    both_rd(7);
    chk(l_rdata, 8'h00, "R7 left wins tie");
    chk(r_rdata, 8'hFF, "R7 R10 right not owner");
    lwr(7, 8'h01);
    both_rd(7);
    chk(r_rdata, 8'h00, "R7 right pending granted");
    chk(l_rdata, 8'hFF, "R10 left no longer owner");
    rwr(7, 8'h01);
  endtask

  task automatic t_bit0();
    lwr(1, 8'hFE);
    both_rd(1);
    chk(l_rdata, 8'h00, "R3 request with upper bits set");
    lwr(1, 8'h01);
    both_rd(1);
    chk(l_rdata, 8'hFF, "R3 release with upper bits clear");
  endtask

  task automatic t_gating();
    // chip-enable high blocks a write
    l_sem = 1; l_ce = 1; l_we = 1; l_addr = 2; l_wdata = 8'h00;
    @(posedge clk); @(negedge clk); idle();
    // strobe low blocks a write
    l_sem = 0; l_ce = 0; l_we = 1; l_addr = 2; l_wdata = 8'h00;
    @(posedge clk); @(negedge clk); idle();
    both_rd(2);
    chk(l_rdata, 8'hFF, "R2 gated writes ignored");
    // take flag 2, then gated read must not refresh rdata
    lwr(2, 8'h00);
    l_sem = 1; l_ce = 1; l_we = 0; l_addr = 2;
    @(posedge clk); @(negedge clk); idle();
    chk(l_rdata, 8'hFF, "R2 gated read leaves rdata");
    both_rd(2);
    chk(l_rdata, 8'h00, "R2 enabled read updates");
    lwr(2, 8'h01);
  endtask

  task automatic t_independent();
    step(1, 1, 0, 8'h00, 1, 1, 6, 8'h00);
    step(1, 0, 6, 8'h00, 1, 0, 0, 8'h00);
    chk(l_rdata, 8'hFF, "R9 left sees flag 6 not its own");
    chk(r_rdata, 8'hFF, "R9 right sees flag 0 not its own");
    step(1, 0, 0, 8'h00, 1, 0, 6, 8'h00);
    chk(l_rdata, 8'h00, "R9 left owns flag 0");
    chk(r_rdata, 8'h00, "R9 right owns flag 6");
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(l_rdata, 8'hFF, "R1 left rdata reset");
    chk(r_rdata, 8'hFF, "R1 right rdata reset");
    rst = 0;
    t_reset();
    t_grant();
    t_handoff();
    t_foreign_release();
    t_contention();
    t_bit0();
    t_gating();
    t_independent();
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule